// File: doc/BRIEF.md
# Host Port Control and Command Registers

This block holds the host-visible control state of a byte-wide host port that feeds a DSP core. The host writes and reads a small register file over a simple synchronous bus. One register carries the transfer-direction request enables, two auxiliary bits and a self-clearing initialize command. A second register lets the host raise any one of 128 core interrupts by supplying a 7-bit vector and a command bit. A third register, read-only, shows the two host-side handshake flags.

Four handshake flags are kept here. The surrounding data path sets and clears them with single-cycle pulses:

- host receive full
- host transmit empty
- core receive full
- core transmit empty

The initialize command forces a subset of these flags. Which flags it forces depends on the enabled transfer directions. The host command is presented to the core as a level request, with an interrupt address equal to twice the vector. The request stays up until the core acknowledges it.

Top module: `hp_host_ctrl`

## Requirements
- R1: A synchronous active-low reset sets the following state. All control bits, the command bit and the vector are cleared. Host transmit empty (`flags_o[1]`) and core transmit empty (`flags_o[3]`) are set. Host receive full (`flags_o[0]`) and core receive full (`flags_o[2]`) are cleared.
- R2: The control register is at address 0. Its layout is:
  - bit 7: initialize
  - bits 6:5: auxiliary
  - bits 4:2: read as 0
  - bit 1: transmit request enable
  - bit 0: receive request enable

  A host write with bit 7 set makes bit 7 read as 1 for exactly the next cycle. After that the bit reads 0.
- R3: When initialize executes with both request enables at 0, it changes none of the four flags.
- R4: When initialize executes with only the receive enable set, it clears host receive full and sets core transmit empty.
- R5: When initialize executes with only the transmit enable set, it sets host transmit empty and clears core receive full.
- R6: When initialize executes with both enables set, it applies all four updates of R4 and R5.
- R7: A flag set pulse sets its flag on the next edge, and a clear pulse clears it. When both arrive together, clear wins. An executing initialize overrides both pulses on the flags it forces.
- R8: When `core_dma_mode` is nonzero, control bits 6:5 read back `core_dma_mode`, and host writes to them are ignored. When it is zero, those bits read the stored auxiliary value.
- R9: The command register is at address 1, with bit 7 as the command bit and bits 6:0 as the vector. When no command is pending, a write stores both fields in the same cycle. `hc_req` follows the command bit, and `hc_addr` is always twice the stored vector.
- R10: While a command is pending, host writes to the command register are ignored.
- R11: `hc_ack` while a command is pending clears the command bit and keeps the vector. `hc_ack` with nothing pending has no effect.
- R12: Address 2 reads `{6'b0, host transmit empty, host receive full}`. Address 3 reads 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_wr_en | input | 1 | Host write strobe, one cycle per write |
| hst_addr | input | 2 | Host register address |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data, combinational from `hst_addr` |
| core_dma_mode | input | 2 | Core-side host DMA mode bits |
| flag_set | input | 4 | Set pulses for the four handshake flags |
| flag_clr | input | 4 | Clear pulses for the four handshake flags |
| flags_o | output | 4 | Flags: 0 host rx full, 1 host tx empty, 2 core rx full, 3 core tx empty |
| hc_req | output | 1 | Host-command interrupt request, level |
| hc_addr | output | 8 | Interrupt address, twice the vector |
| hc_ack | input | 1 | Core acknowledge of the host command |

## Verification
Initialize is tried under all four combinations of the request enables. Before each run the flags are preloaded to the opposite of what initialize would force, so every forced flag visibly moves and every untouched flag visibly stays. Initialize is also run while conflicting set and clear pulses arrive in the same cycle, which separates the override order from plain pulse handling. The command path is tried with writes during a pending command, and with acknowledges both with and without a pending command. The DMA-mode readback is tried with writes made while the mode is nonzero. A long random mix of all these operations, compared against a bench model, catches interactions the directed cases miss.

// File: rtl/hp_pkg.sv
// Package: shared constants of the host port control block.
// Assumes a four-flag handshake set with fixed indices used by all modules.
package hp_pkg;

    localparam int NUM_FLAGS = 4;

    // Flag indices
    localparam int FLG_H_RXF = 0;   // host receive data full
    localparam int FLG_H_TXE = 1;   // host transmit empty
    localparam int FLG_C_RXF = 2;   // core receive full
    localparam int FLG_C_TXE = 3;   // core transmit empty

    // Reset value of the flags; also the value initialize forces
    localparam logic [NUM_FLAGS-1:0] FLAG_RST = 4'b1010;

    // Host register addresses
    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_CMD  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // Control register bit positions
    localparam int CTL_INIT  = 7;
    localparam int CTL_AUX_H = 6;
    localparam int CTL_AUX_L = 5;
    localparam int CTL_TXEN  = 1;
    localparam int CTL_RXEN  = 0;

endpackage

// File: rtl/hp_flag_cell.sv
// Module: one handshake flag with set/clear pulses and a forcing port.
// Assumes the force port comes from the initialize sequencer and has the
// highest priority; among the pulses, clear dominates set.
module hp_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic force_en_i,
    input  logic force_val_i,
    output logic flag_o
);

    logic flag_q;

    // Flag state: force > clear > set > hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= RST_VAL;
        else if (force_en_i)
            flag_q <= force_val_i;
        else if (clr_i)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
    end

    assign flag_o = flag_q;

    // R7: an executing initialize overrides the pulses
    a_r7_force_wins: assert property (@(posedge clk) disable iff (!rst_n)
        force_en_i |=> flag_q == $past(force_val_i));

    // R7: clear dominates set when not forced
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !force_en_i) |=> !flag_q);

endmodule

// File: rtl/hp_ctrl_reg.sv
// Module: interface control register with a self-clearing initialize command.
// Holds the request enables and auxiliary bits. Initialize is latched on the
// host write and executes one cycle later, producing per-flag force enables.
// Assumes the write strobe is a single-cycle pulse already decoded for this
// register.
module hp_ctrl_reg
    import hp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_i,
    input  logic                 init_wr_i,
    input  logic [1:0]           aux_wr_i,
    input  logic                 txen_wr_i,
    input  logic                 rxen_wr_i,
    input  logic [1:0]           dma_mode_i,
    output logic [7:0]           ctrl_byte_o,
    output logic [NUM_FLAGS-1:0] force_en_o,
    output logic [NUM_FLAGS-1:0] force_val_o
);

    logic       init_q;
    logic [1:0] aux_q;
    logic       txen_q;
    logic       rxen_q;
    logic       dma_on;

    assign dma_on = |dma_mode_i;

    // Initialize command: set by a host write, cleared on the next edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            init_q <= 1'b0;
        else
            init_q <= wr_i & init_wr_i;
    end

    // Request enables and auxiliary bits; auxiliary locked while DMA mode is on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txen_q <= 1'b0;
            rxen_q <= 1'b0;
            aux_q  <= 2'b00;
        end else if (wr_i) begin
            txen_q <= txen_wr_i;
            rxen_q <= rxen_wr_i;
            if (!dma_on)
                aux_q <= aux_wr_i;
        end
    end

    // Force enables selected by the transfer directions enabled
    always_comb begin
        force_en_o = '0;
        force_en_o[FLG_H_RXF] = init_q & rxen_q;
        force_en_o[FLG_C_TXE] = init_q & rxen_q;
        force_en_o[FLG_H_TXE] = init_q & txen_q;
        force_en_o[FLG_C_RXF] = init_q & txen_q;
    end

    assign force_val_o = FLAG_RST;

    // Read view of the register
    always_comb begin
        ctrl_byte_o = '0;
        ctrl_byte_o[CTL_INIT] = init_q;
        ctrl_byte_o[CTL_AUX_H:CTL_AUX_L] = dma_on ? dma_mode_i : aux_q;
        ctrl_byte_o[CTL_TXEN] = txen_q;
        ctrl_byte_o[CTL_RXEN] = rxen_q;
    end

    // R2: initialize lasts a single cycle unless rewritten
    a_r2_init_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (init_q && !(wr_i && init_wr_i)) |=> !init_q);

    // R8: auxiliary bits cannot change while DMA mode is nonzero
    a_r8_aux_locked: assert property (@(posedge clk) disable iff (!rst_n)
        dma_on |=> $stable(aux_q));

    // R3: no direction enabled means nothing is forced
    a_r3_no_force: assert property (@(posedge clk) disable iff (!rst_n)
        (!txen_q && !rxen_q) |-> (force_en_o == '0));

endmodule

// File: rtl/hp_cmd_reg.sv
// Module: command vector register that raises a host-command interrupt.
// The command bit is a level request that the core clears with an acknowledge.
// The vector survives the acknowledge. Host writes are dropped while a command
// is pending. Assumes the write strobe is already decoded for this register.
module hp_cmd_reg #(
    parameter int VEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [VEC_W:0]   wdata_i,
    input  logic             ack_i,
    output logic             pend_o,
    output logic [VEC_W-1:0] vec_o
);

    logic             pend_q;
    logic [VEC_W-1:0] vec_q;

    // Command bit and vector: acknowledge clears, writes only when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            vec_q  <= '0;
        end else if (pend_q) begin
            if (ack_i)
                pend_q <= 1'b0;
        end else if (wr_i) begin
            pend_q <= wdata_i[VEC_W];
            vec_q  <= wdata_i[VEC_W-1:0];
        end
    end

    assign pend_o = pend_q;
    assign vec_o  = vec_q;

    // R10: a pending command holds its bit and vector until acknowledged
    a_r10_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ack_i) |=> (pend_q && $stable(vec_q)));

    // R11: acknowledge clears the command and keeps the vector
    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && ack_i) |=> (!pend_q && $stable(vec_q)));

endmodule

// File: rtl/hp_host_ctrl.sv
// Module: top of the host port control and command registers.
// Decodes host writes, muxes host reads, and holds the four handshake flags.
// Assumes a single-cycle write strobe and a combinational read path.
module hp_host_ctrl
    import hp_pkg::*;
#(
    parameter int VEC_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hst_wr_en,
    input  logic [1:0]           hst_addr,
    input  logic [VEC_W:0]       hst_wdata,
    output logic [VEC_W:0]       hst_rdata,
    input  logic [1:0]           core_dma_mode,
    input  logic [NUM_FLAGS-1:0] flag_set,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 hc_req,
    output logic [VEC_W:0]       hc_addr,
    input  logic                 hc_ack
);

    localparam int DATA_W = VEC_W + 1;

    reg_sel_e             sel;
    logic                 wr_ctrl;
    logic                 wr_cmd;
    logic [7:0]           ctrl_byte;
    logic [NUM_FLAGS-1:0] force_en;
    logic [NUM_FLAGS-1:0] force_val;
    logic                 pend;
    logic [VEC_W-1:0]     vec;

    assign sel     = reg_sel_e'(hst_addr);
    assign wr_ctrl = hst_wr_en && (sel == REG_CTRL);
    assign wr_cmd  = hst_wr_en && (sel == REG_CMD);

    hp_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_ctrl),
        .init_wr_i   (hst_wdata[CTL_INIT]),
        .aux_wr_i    (hst_wdata[CTL_AUX_H:CTL_AUX_L]),
        .txen_wr_i   (hst_wdata[CTL_TXEN]),
        .rxen_wr_i   (hst_wdata[CTL_RXEN]),
        .dma_mode_i  (core_dma_mode),
        .ctrl_byte_o (ctrl_byte),
        .force_en_o  (force_en),
        .force_val_o (force_val)
    );

    hp_cmd_reg #(.VEC_W(VEC_W)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_cmd),
        .wdata_i (hst_wdata),
        .ack_i   (hc_ack),
        .pend_o  (pend),
        .vec_o   (vec)
    );

    // One flag cell per handshake flag, reset value taken from the package
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        hp_flag_cell #(.RST_VAL(FLAG_RST[i])) u_flag (
            .clk         (clk),
            .rst_n       (rst_n),
            .set_i       (flag_set[i]),
            .clr_i       (flag_clr[i]),
            .force_en_i  (force_en[i]),
            .force_val_i (force_val[i]),
            .flag_o      (flags_o[i])
        );
    end

    assign hc_req  = pend;
    assign hc_addr = {vec, 1'b0};

    // Host read mux
    always_comb begin
        unique case (sel)
            REG_CTRL: hst_rdata = DATA_W'(ctrl_byte);
            REG_CMD:  hst_rdata = {pend, vec};
            REG_STAT: hst_rdata = DATA_W'({flags_o[FLG_H_TXE], flags_o[FLG_H_RXF]});
            default:  hst_rdata = '0;
        endcase
    end

    // R9: an idle command write with the command bit raises the request
    a_r9_write_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !hc_req && hst_wdata[VEC_W]) |=>
            (hc_req && hc_addr == {$past(hst_wdata[VEC_W-1:0]), 1'b0}));

    // R12: writes to the status or unused address leave the flags alone
    a_r12_no_side_write: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr_en && hst_addr[1] && flag_set == '0 && flag_clr == '0 &&
         force_en == '0) |=> $stable(flags_o));

endmodule

// File: tb/test_hp_host_ctrl.sv
// Bench: directed corner cases followed by seeded random operations, all
// compared against a behavioural model kept in this file.
module test_hp_host_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hst_wr_en = 1'b0;
    logic [1:0] hst_addr = 2'd0;
    logic [7:0] hst_wdata = 8'd0;
    logic [7:0] hst_rdata;
    logic [1:0] core_dma_mode = 2'd0;
    logic [3:0] flag_set = 4'd0;
    logic [3:0] flag_clr = 4'd0;
    logic [3:0] flags_o;
    logic       hc_req;
    logic [7:0] hc_addr;
    logic       hc_ack = 1'b0;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;
    string cur = "R1";

    // Model state
    logic       m_init, m_tx, m_rx, m_pend;
    logic [1:0] m_aux;
    logic [6:0] m_vec;
    logic [3:0] m_flags;

    always #5 clk = ~clk;

    hp_host_ctrl i_hp_host_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .hst_wr_en     (hst_wr_en),
        .hst_addr      (hst_addr),
        .hst_wdata     (hst_wdata),
        .hst_rdata     (hst_rdata),
        .core_dma_mode (core_dma_mode),
        .flag_set      (flag_set),
        .flag_clr      (flag_clr),
        .flags_o       (flags_o),
        .hc_req        (hc_req),
        .hc_addr       (hc_addr),
        .hc_ack        (hc_ack)
    );

    task automatic check(string what, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", cur, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [1:0] a);
        case (a)
            2'd0: return {m_init, (core_dma_mode != 2'd0) ? core_dma_mode : m_aux,
                          3'b000, m_tx, m_rx};
            2'd1: return {m_pend, m_vec};
            2'd2: return {6'b0, m_flags[1], m_flags[0]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_init = 0; m_tx = 0; m_rx = 0; m_pend = 0;
        m_aux = 0; m_vec = 0; m_flags = 4'b1010;
    endtask

    // Model update for one clock edge with the inputs currently driven
    task automatic model_edge();
        logic [3:0] nf;
        nf = (m_flags | flag_set) & ~flag_clr;
        if (m_init) begin
            if (m_rx) begin nf[0] = 1'b0; nf[3] = 1'b1; end
            if (m_tx) begin nf[1] = 1'b1; nf[2] = 1'b0; end
        end
        m_flags = nf;
        m_init = hst_wr_en && hst_addr == 2'd0 && hst_wdata[7];
        if (hst_wr_en && hst_addr == 2'd0) begin
            m_tx = hst_wdata[1];
            m_rx = hst_wdata[0];
            if (core_dma_mode == 2'd0) m_aux = hst_wdata[6:5];
        end
        if (m_pend) begin
            if (hc_ack) m_pend = 1'b0;
        end else if (hst_wr_en && hst_addr == 2'd1) begin
            m_pend = hst_wdata[7];
            m_vec = hst_wdata[6:0];
        end
    endtask

    task automatic check_all();
        check("flags", {4'h0, flags_o}, {4'h0, m_flags});
        check("hc_req", {7'h0, hc_req}, {7'h0, m_pend});
        check("hc_addr", hc_addr, {m_vec, 1'b0});
        for (int a = 0; a < 4; a++) begin
            hst_addr = a[1:0];
            #1;
            check($sformatf("read addr %0d", a), hst_rdata, exp_read(a[1:0]));
        end
    endtask

    // One cycle: drive, clock, update model, probe outputs at falling edge
    task automatic step(logic wr, logic [1:0] addr, logic [7:0] wd,
                        logic [3:0] st, logic [3:0] cl, logic ack);
        hst_wr_en = wr; hst_addr = addr; hst_wdata = wd;
        flag_set = st; flag_clr = cl; hc_ack = ack;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        hst_wr_en = 0; flag_set = 0; flag_clr = 0; hc_ack = 0;
        check_all();
    endtask

    task automatic idle();
        step(0, 2'd0, 8'h00, 4'h0, 4'h0, 0);
    endtask

    // Preload flags to the opposite of what initialize forces
    task automatic preload_opposite();
        cur = "R7";
        step(0, 2'd0, 8'h00, 4'b0101, 4'b1010, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur = "R1";
        check_all();

        // R7: set/clear pulses, clear wins
        cur = "R7";
        step(0, 2'd0, 8'h00, 4'b0101, 4'b0000, 0);
        step(0, 2'd0, 8'h00, 4'b0100, 4'b0100, 0);
        step(0, 2'd0, 8'h00, 4'b0000, 4'b1111, 0);

        // R2 and R3: initialize with no direction enabled
        preload_opposite();
        cur = "R2";
        step(1, 2'd0, 8'h80, 4'h0, 4'h0, 0);
        cur = "R3";
        idle();
        idle();

        // R4: receive direction only
        preload_opposite();
        cur = "R4";
        step(1, 2'd0, 8'h81, 4'h0, 4'h0, 0);
        idle();

        // R5: transmit direction only
        preload_opposite();
        cur = "R5";
        step(1, 2'd0, 8'h82, 4'h0, 4'h0, 0);
        idle();

        // R6: both directions
        preload_opposite();
        cur = "R6";
        step(1, 2'd0, 8'h83, 4'h0, 4'h0, 0);
        idle();

        // R7: conflicting pulses during execution, initialize wins
        cur = "R7";
        step(1, 2'd0, 8'h83, 4'h0, 4'h0, 0);
        step(0, 2'd0, 8'h00, 4'b0101, 4'b1010, 0);

        // R8: DMA mode readback and write lock
        cur = "R8";
        step(1, 2'd0, 8'h20, 4'h0, 4'h0, 0);
        core_dma_mode = 2'b11;
        step(1, 2'd0, 8'h40, 4'h0, 4'h0, 0);
        core_dma_mode = 2'b10;
        idle();
        core_dma_mode = 2'b00;
        idle();

        // R9: command write raises the request
        cur = "R9";
        step(1, 2'd1, 8'hC5, 4'h0, 4'h0, 0);
        // R10: writes while pending are dropped
        cur = "R10";
        step(1, 2'd1, 8'h83, 4'h0, 4'h0, 0);
        step(1, 2'd1, 8'h00, 4'h0, 4'h0, 0);
        // R11: acknowledge clears, vector kept; ack when idle has no effect
        cur = "R11";
        step(0, 2'd0, 8'h00, 4'h0, 4'h0, 1);
        step(0, 2'd0, 8'h00, 4'h0, 4'h0, 1);
        step(1, 2'd1, 8'hFF, 4'h0, 4'h0, 0);
        step(1, 2'd1, 8'h81, 4'h0, 4'h0, 1);
        step(1, 2'd1, 8'h00, 4'h0, 4'h0, 0);
        cur = "R9";
        step(1, 2'd1, 8'h00, 4'h0, 4'h0, 0);

        // R12: writes to status and unused address
        cur = "R12";
        step(1, 2'd2, 8'hFF, 4'h0, 4'h0, 0);
        step(1, 2'd3, 8'hFF, 4'h0, 4'h0, 0);

        // Random mix
        cur = "R7 random";
        void'($urandom(32'h00C0FFEE));
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] st, cl;
            logic [7:0] wd;
            logic       wr, ack;
            logic [1:0] ad;
            wr  = ($urandom % 3) == 0;
            ad  = 2'($urandom % 4);
            wd  = 8'($urandom);
            st  = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            cl  = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            ack = ($urandom % 4) == 0;
            if (($urandom % 16) == 0) core_dma_mode = 2'($urandom);
            step(wr, ad, wd, st, cl, ack);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule